// File: doc/BRIEF.md
# Programmable Horizontal Line Sampler

This block produces the pixel timing for one video line at a time. It derives a 100 ns tick from a fast reference clock. After each rising edge of the horizontal sync input it waits a programmed number of ticks, then issues 64 single-cycle sample strobes spaced a programmed number of ticks apart. Each strobe carries the pixel index (0 to 63) that a downstream address counter and converter use. A window-enable output stays high from the first strobe of a line through its last strobe.

A small write port sets two values: the start offset (in ticks after the sync edge) and the sample spacing (in ticks). A short spacing over a narrow offset range zooms in on part of the line. The default spacing of 8 ticks spreads the 64 samples over 51.2 us, about the visible width of a line. Writes go to pending registers and are copied into the working registers only at a sync edge, so every line is sampled with one consistent setting. A sync edge always starts a new line. If the programmed window runs past the next sync, the current line simply ends with fewer strobes.

Top module: `hline_sampler`

## Requirements
- R1: While reset is asserted and after its release, until the first sync rising edge, `sample_stb` and `window_en` are 0 and `pix_addr` is 0.
- R2: For a line started by a sync rising edge registered at clock edge E, with offset O, the first strobe is high in the cycle following clock edge E + (O+1)*TICK_DIV.
- R3: Strobes follow every P ticks (P*TICK_DIV clock cycles), where P is the line's spacing. There are exactly 64 per line, with `pix_addr` equal to 0, 1, ..., 63 on successive strobes.
- R4: `window_en` is high from the cycle of the first strobe through the cycle of the last strobe of a line, and low at all other times.
- R5: A spacing value of 0 is used as 1 (one tick between strobes).
- R6: A write affects only lines whose sync edge comes after the write. A write in the same cycle as a sync rising edge applies to the following line, not the one being started.
- R7: A sync rising edge during a line ends that line: no further strobes, and `window_en` is low in the next cycle. The new line starts its own timing from that edge.
- R8: `cfg_sel` = 0 writes the start offset from all of `cfg_wdata`. `cfg_sel` = 1 writes the spacing from the low 8 bits of `cfg_wdata`.
- R9: Only a rising edge of `hsync` starts a line. Holding `hsync` high starts nothing further.
- R10: After reset the offset is 0 and the spacing is 8, so the first strobe of a line follows edge E+TICK_DIV and the last follows edge E+505*TICK_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (TICK_DIV cycles per 100 ns tick) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync | input | 1 | Horizontal sync, synchronous to clk, rising edge starts a line |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 start offset, 1 sample spacing |
| cfg_wdata | input | 12 | Write data |
| sample_stb | output | 1 | One-cycle pixel sample strobe |
| window_en | output | 1 | High during the sampling window of the line |
| pix_addr | output | 6 | Index of the pixel being strobed |

## Verification
The hardest cases to reach are a sync edge that cuts a window short after a known number of strobes, and a register write that lands in exactly the cycle the sync edge is seen. The stimulus reaches the first by programming a long window and pulsing sync a fixed number of cycles into it. It reaches the second by raising `cfg_we` and `hsync` on the same clock edge, then holding sync high for hundreds of cycles. A schedule-based model predicts every strobe cycle, address and window state from the sync edge times and the settings in force. That model is compared with the outputs on every cycle, and per-line strobe counts and first-strobe positions are checked against fixed values.

// File: rtl/hline_pkg.sv
package hline_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_DONE   = 2'd3
  } line_state_t;

  localparam logic SEL_OFFSET = 1'b0;
  localparam logic SEL_PERIOD = 1'b1;
endpackage

// File: rtl/hline_tick_gen.sv
module hline_tick_gen #(
  parameter int TICK_DIV = 10,
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Divider never exceeds its terminal value
  assert_div_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/hline_cfg_regs.sv
module hline_cfg_regs
  import hline_pkg::*;
#(
  parameter int CFG_W      = 12,
  parameter int PERIOD_W   = 8,
  parameter int RST_OFFSET = 0,
  parameter int RST_PERIOD = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                sel,
  input  logic [CFG_W-1:0]    wdata,
  input  logic                load,
  output logic [CFG_W-1:0]    act_offset,
  output logic [PERIOD_W-1:0] act_period
);
  logic [CFG_W-1:0]    pend_off_q, pend_off_d, act_off_d;
  logic [PERIOD_W-1:0] pend_per_q, pend_per_d, act_per_d;
  logic [CFG_W-1:0]    act_off_q;
  logic [PERIOD_W-1:0] act_per_q;

  always_comb begin
    pend_off_d = pend_off_q;
    pend_per_d = pend_per_q;
    if (we && sel == SEL_OFFSET) pend_off_d = wdata;
    if (we && sel == SEL_PERIOD) pend_per_d = wdata[PERIOD_W-1:0];
  end

  always_comb begin
    act_off_d = act_off_q;
    act_per_d = act_per_q;
    if (load) begin
      act_off_d = pend_off_q;
      act_per_d = (pend_per_q == '0) ? PERIOD_W'(1) : pend_per_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_off_q <= CFG_W'(RST_OFFSET);
      pend_per_q <= PERIOD_W'(RST_PERIOD);
      act_off_q  <= CFG_W'(RST_OFFSET);
      act_per_q  <= PERIOD_W'(RST_PERIOD);
    end else begin
      pend_off_q <= pend_off_d;
      pend_per_q <= pend_per_d;
      act_off_q  <= act_off_d;
      act_per_q  <= act_per_d;
    end
  end

  assign act_offset = act_off_q;
  assign act_period = act_per_q;

  assert_period_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_period != '0);

  assert_hold_between_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_offset) && $stable(act_period)));
endmodule

// File: rtl/hline_line_fsm.sv
module hline_line_fsm
  import hline_pkg::*;
#(
  parameter int CFG_W       = 12,
  parameter int PERIOD_W    = 8,
  parameter int NUM_SAMPLES = 64,
  localparam int ADDR_W = $clog2(NUM_SAMPLES),
  localparam int SCNT_W = ADDR_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_edge,
  input  logic                tick,
  input  logic [CFG_W-1:0]    act_offset,
  input  logic [PERIOD_W-1:0] act_period,
  output logic                sample_stb,
  output logic                window_en,
  output logic [ADDR_W-1:0]   pix_addr
);
  localparam logic [SCNT_W-1:0] FULL = SCNT_W'(NUM_SAMPLES);

  line_state_t         state_q, state_d;
  logic [CFG_W-1:0]    ocnt_q, ocnt_d;
  logic [PERIOD_W-1:0] pcnt_q, pcnt_d;
  logic [SCNT_W-1:0]   scnt_q, scnt_d;
  logic                stb_q, stb_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                fire;

  always_comb begin
    state_d = state_q;
    ocnt_d  = ocnt_q;
    pcnt_d  = pcnt_q;
    fire    = 1'b0;
    if (hs_edge) begin
      state_d = ST_WAIT;
      ocnt_d  = '0;
      pcnt_d  = '0;
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (tick) begin
            if (ocnt_q == act_offset) begin
              fire    = 1'b1;
              state_d = ST_SAMPLE;
              pcnt_d  = '0;
            end else begin
              ocnt_d = ocnt_q + 1'b1;
            end
          end
        end
        ST_SAMPLE: begin
          if (scnt_q == FULL) begin
            state_d = ST_DONE;
          end else if (tick) begin
            if (pcnt_q == act_period - 1'b1) begin
              fire   = 1'b1;
              pcnt_d = '0;
            end else begin
              pcnt_d = pcnt_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stb_d  = fire;
    addr_d = addr_q;
    scnt_d = scnt_q;
    if (hs_edge) begin
      scnt_d = '0;
    end else if (fire) begin
      addr_d = scnt_q[ADDR_W-1:0];
      scnt_d = scnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ocnt_q  <= '0;
      pcnt_q  <= '0;
      scnt_q  <= '0;
      stb_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      ocnt_q  <= ocnt_d;
      pcnt_q  <= pcnt_d;
      scnt_q  <= scnt_d;
      stb_q   <= stb_d;
      addr_q  <= addr_d;
    end
  end

  assign sample_stb = stb_q;
  assign window_en  = (state_q == ST_SAMPLE);
  assign pix_addr   = addr_q;

  assert_stb_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> window_en);

  assert_count_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scnt_q <= FULL);

  assert_stb_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(tick));

  assert_sync_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hs_edge |=> (!sample_stb && !window_en));
endmodule

// File: rtl/hline_sampler.sv
module hline_sampler #(
  parameter int TICK_DIV    = 10,
  parameter int NUM_SAMPLES = 64,
  parameter int CFG_W       = 12,
  parameter int PERIOD_W    = 8,
  parameter int RST_OFFSET  = 0,
  parameter int RST_PERIOD  = 8,
  parameter int RST_STAGES  = 2,
  localparam int ADDR_W = $clog2(NUM_SAMPLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              sample_stb,
  output logic              window_en,
  output logic [ADDR_W-1:0] pix_addr
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_int_n;
  logic                  hs_q;
  logic                  hs_edge;
  logic                  tick;
  logic [CFG_W-1:0]      act_offset;
  logic [PERIOD_W-1:0]   act_period;

  // reset: asserted at once, released after RST_STAGES clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[RST_STAGES-1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) hs_q <= 1'b0;
    else            hs_q <= hsync;
  end
  assign hs_edge = hsync & ~hs_q;

  hline_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (hs_edge),
    .tick    (tick)
  );

  hline_cfg_regs #(
    .CFG_W(CFG_W), .PERIOD_W(PERIOD_W),
    .RST_OFFSET(RST_OFFSET), .RST_PERIOD(RST_PERIOD)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .we         (cfg_we),
    .sel        (cfg_sel),
    .wdata      (cfg_wdata),
    .load       (hs_edge),
    .act_offset (act_offset),
    .act_period (act_period)
  );

  hline_line_fsm #(
    .CFG_W(CFG_W), .PERIOD_W(PERIOD_W), .NUM_SAMPLES(NUM_SAMPLES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .hs_edge    (hs_edge),
    .tick       (tick),
    .act_offset (act_offset),
    .act_period (act_period),
    .sample_stb (sample_stb),
    .window_en  (window_en),
    .pix_addr   (pix_addr)
  );

  // a held sync level produces no second edge
  assert_edge_once_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    hs_edge |=> !hs_edge);
endmodule

// File: tb/test_hline_sampler.sv
`timescale 1ns/1ps
module test_hline_sampler;
  localparam int DIV = 10;
  localparam int NS  = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hsync;
  logic        cfg_we;
  logic        cfg_sel;
  logic [11:0] cfg_wdata;
  logic        sample_stb;
  logic        window_en;
  logic [5:0]  pix_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  // behavioural model state
  int  cyc = 0;
  int  line_no = 0;
  bit  line_valid = 0;
  int  line_e = 0;
  int  m_off = 0, m_per = 8;
  int  pend_off = 0, pend_per = 8;
  bit  hs_prev = 0;
  int  dut_cnt[16];
  int  exp_cnt[16];
  int  first_rel[16];

  always #5 clk = ~clk;

  hline_sampler i_hline_sampler (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .sample_stb(sample_stb), .window_en(window_en), .pix_addr(pix_addr)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // model update on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      line_valid = 0; pend_off = 0; pend_per = 8; m_off = 0; m_per = 8; hs_prev = 0;
    end else begin
      if (hsync && !hs_prev) begin
        line_no++;
        line_valid = 1;
        line_e = cyc;
        m_off = pend_off;
        m_per = (pend_per == 0) ? 1 : pend_per;
      end
      if (cfg_we) begin
        if (cfg_sel == 1'b0) pend_off = cfg_wdata;
        else                 pend_per = cfg_wdata[7:0];
      end
      hs_prev = hsync;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      int  rel, t, k, s0, s63;
      bit  e_stb, e_win;
      int  e_addr;
      e_stb = 0; e_win = 0; e_addr = 0;
      if (line_valid) begin
        rel = cyc - line_e;
        s0  = line_e + (m_off + 1) * DIV;
        s63 = line_e + (m_off + 1 + (NS - 1) * m_per) * DIV;
        e_win = (cyc >= s0) && (cyc <= s63);
        if (rel > 0 && rel % DIV == 0) begin
          t = rel / DIV;
          if (t >= m_off + 1 && ((t - m_off - 1) % m_per) == 0) begin
            k = (t - m_off - 1) / m_per;
            if (k < NS) begin e_stb = 1; e_addr = k; end
          end
        end
      end
      check(cur_req, int'(sample_stb), int'(e_stb), "sample_stb");
      check(cur_req, int'(window_en), int'(e_win), "window_en");
      if (e_stb) check(cur_req, int'(pix_addr), e_addr, "pix_addr");
      if (e_stb) exp_cnt[line_no]++;
      if (sample_stb) begin
        if (dut_cnt[line_no] == 0) first_rel[line_no] = cyc - line_e;
        dut_cnt[line_no]++;
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 12'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_hs();
    @(negedge clk);
    hsync = 1'b1;
    @(negedge clk);
    hsync = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    foreach (dut_cnt[i]) begin dut_cnt[i] = 0; exp_cnt[i] = 0; first_rel[i] = -1; end
    rst_n = 1'b0; hsync = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    wait_cyc(3);
    // R1: outputs quiet during reset
    check("R1", int'(sample_stb), 0, "stb in reset");
    check("R1", int'(window_en), 0, "window in reset");
    check("R1", int'(pix_addr), 0, "addr in reset");
    rst_n = 1'b1;
    cmp_on = 1;
    wait_cyc(30);  // R1: idle, compared every cycle

    // line 1: reset defaults; pending writes in mid-line (R10, R6, R8)
    cur_req = "R10";
    pulse_hs();
    wait_cyc(100);
    wr(1'b0, 5);
    wr(1'b1, 3);
    wait_cyc(5100);
    check("R10", dut_cnt[1], 64, "strobes on default line");
    check("R10", first_rel[1], DIV, "first strobe default line");

    // line 2: offset 5, spacing 3 (R2, R3, R8)
    cur_req = "R3";
    pulse_hs();
    wait_cyc(200);
    wr(1'b1, 0);
    wr(1'b0, 2);
    wait_cyc(1900);
    check("R3", dut_cnt[2], 64, "strobes with spacing 3");
    check("R2", first_rel[2], 6 * DIV, "first strobe offset 5");
    check("R8", exp_cnt[2], 64, "model strobes line 2");

    // line 3: spacing 0 used as 1 (R5)
    cur_req = "R5";
    pulse_hs();
    wait_cyc(800);
    check("R5", dut_cnt[3], 64, "strobes with spacing 0");
    check("R5", first_rel[3], 3 * DIV, "first strobe offset 2");
    wr(1'b0, 10);
    wr(1'b1, 8);

    // line 4 aborted by line 5 (R7)
    cur_req = "R7";
    pulse_hs();
    wait_cyc(2000);
    pulse_hs();
    check("R7", int'(dut_cnt[4] < 64), 1, "aborted line short");
    check("R7", dut_cnt[4], exp_cnt[4], "aborted line count");
    wait_cyc(5300);
    check("R7", dut_cnt[5], 64, "line after abort");

    // line 6: write coincides with sync edge, sync then held high (R6, R9)
    cur_req = "R6";
    @(negedge clk);
    hsync = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 12'd30;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_req = "R9";
    wait_cyc(600);
    hsync = 1'b0;
    wait_cyc(4800);
    check("R6", first_rel[6], 11 * DIV, "coincident write not used");
    check("R9", dut_cnt[6], 64, "held sync single line");
    check("R9", line_no, 6, "model line count");

    // line 7 uses the coincident write (R6)
    cur_req = "R6";
    pulse_hs();
    wait_cyc(5500);
    check("R6", first_rel[7], 31 * DIV, "write used on next line");
    check("R4", dut_cnt[7], 64, "strobes on line 7");
    check("R4", int'(window_en), 0, "window closed after line");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule